// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors signal each other through per-channel "occupied" flags. Each processor owns a small register bank with four registers: control, mask, set/clear and status. A processor posts a message on channel n by setting its own outgoing flag n. The peer sees that flag as a pending receive and acknowledges it, which clears the flag. Payload memory is outside the block; only the flags are kept here.

Each processor has its own register port, with address, write data, write enable and read data. Reads may target any address in the map. Writes from a port change only the bank that belongs to that port's processor. Each processor receives two interrupts:

- a receive interrupt, raised while a peer flag is set and that channel's receive mask bit is clear;
- a transmit-free interrupt, raised while one of its own flags is clear and that channel's transmit mask bit is clear.

Each interrupt has an enable bit in the control register. A configuration word and a version word at the top of the map let software discover the channel count and the revision.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After reset, every flag is clear, every implemented mask bit is set, both enables are off and all four interrupts are low.
- R2: A write of 1 to bit 16+n of a processor's set/clear word (bank base + 0x8) sets that processor's outgoing flag n. The flag is visible in status bit n (bank base + 0xC) from the next cycle. Bits written as 0 have no effect, and the set/clear word always reads as zero.
- R3: A write of 1 to bit n of a processor's set/clear word clears the peer's outgoing flag n.
- R4: If one processor sets flag n in the same cycle that its peer acknowledges flag n, the flag ends up set.
- R5: The receive interrupt of processor p is control bit 0 ANDed with the OR over channels of (peer flag AND NOT mask bit n). Mask bits 15:0 sit at bank base + 0x4.
- R6: The transmit-free interrupt of processor p is control bit 16 ANDed with the OR over implemented channels of (NOT own flag AND NOT mask bit 16+n).
- R7: The control word (bank base + 0x0) keeps bit 0 and bit 16. All other bits read as zero.
- R8: Bank 0 is at 0x000 and bank 1 is at 0x010. A write from port p to the other processor's bank changes nothing.
- R9: The channel count NUM_CH is a parameter of at most 16. Flag, mask and set bits for channels at or above NUM_CH read as zero and ignore writes.
- R10: Address 0x3F0 reads NUM_CH in bits 7:0. Address 0x3F4 reads the minor revision in bits 3:0 and the major revision in bits 7:4. Writes to both addresses are ignored, and any other unmapped or misaligned address reads zero.
- R11: When both ports write in the same cycle, each write takes effect in its own bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_we | input | 1 | Processor 0 write strobe |
| p0_addr | input | 10 | Processor 0 byte address |
| p0_wdata | input | 32 | Processor 0 write data |
| p0_rdata | output | 32 | Processor 0 read data, combinational from p0_addr |
| p1_we | input | 1 | Processor 1 write strobe |
| p1_addr | input | 10 | Processor 1 byte address |
| p1_wdata | input | 32 | Processor 1 write data |
| p1_rdata | output | 32 | Processor 1 read data, combinational from p1_addr |
| rx_irq | output | 2 | Receive interrupt, bit p for processor p |
| tx_irq | output | 2 | Transmit-free interrupt, bit p for processor p |

## Verification
A write is captured at the rising edge where its strobe is high. Every flag, mask and enable it touches is therefore visible on both read ports and on all four interrupts right after that edge, with no further latency. Read data depends combinationally on the address, so it follows the address in the same cycle. The bench drives writes at the falling edge and releases them at the next falling edge. It then checks the interrupts and sweeps every register address on both ports within that half cycle, comparing each value against its own model, which it updated when it issued the write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int MAX_CH = 16;
    localparam int NPROC  = 2;

    localparam logic [ADDR_W-1:0] CFG_ADDR = 10'h3F0;
    localparam logic [ADDR_W-1:0] VER_ADDR = 10'h3F4;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_MASK   = 2'd1,
        REG_SETCLR = 2'd2,
        REG_STAT   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic              hit;
        logic              bank;
        reg_sel_e          sel;
    } dec_t;

    typedef struct packed {
        logic              rx_en;
        logic              tx_en;
        logic [MAX_CH-1:0] rx_mask;
        logic [MAX_CH-1:0] tx_mask;
    } bank_state_t;

    typedef struct packed {
        logic [MAX_CH-1:0] set_req;
        logic [MAX_CH-1:0] ack_req;
    } flag_cmd_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.hit  = (a[ADDR_W-1:5] == '0) && (a[1:0] == 2'b00);
        d.bank = a[4];
        d.sel  = reg_sel_e'(a[3:2]);
        return d;
    endfunction

    function automatic logic [MAX_CH-1:0] ch_mask(input int n);
        logic [MAX_CH-1:0] m;
        for (int i = 0; i < MAX_CH; i++) m[i] = (i < n);
        return m;
    endfunction

endpackage

// File: rtl/mbox_bank.sv
module mbox_bank
    import mbox_pkg::*;
#(
    parameter int NUM_CH  = 8,
    parameter int BANK_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [MAX_CH-1:0] own_occ,
    input  logic [MAX_CH-1:0] peer_occ,
    output bank_state_t       st,
    output flag_cmd_t         cmd,
    output logic              rx_irq,
    output logic              tx_irq
);

    localparam logic [MAX_CH-1:0] CH_MASK = ch_mask(NUM_CH);

    dec_t dec;
    logic wr_hit;

    always_comb begin
        dec    = decode(req.addr);
        wr_hit = req.we && dec.hit && (dec.bank == 1'(BANK_ID));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.rx_en   <= 1'b0;
            st.tx_en   <= 1'b0;
            st.rx_mask <= CH_MASK;
            st.tx_mask <= CH_MASK;
        end else if (wr_hit) begin
            case (dec.sel)
                REG_CTRL: begin
                    st.rx_en <= req.wdata[0];
                    st.tx_en <= req.wdata[16];
                end
                REG_MASK: begin
                    st.rx_mask <= req.wdata[15:0]  & CH_MASK;
                    st.tx_mask <= req.wdata[31:16] & CH_MASK;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        cmd = '0;
        if (wr_hit && dec.sel == REG_SETCLR) begin
            cmd.set_req = req.wdata[31:16] & CH_MASK;
            cmd.ack_req = req.wdata[15:0]  & CH_MASK;
        end
    end

    always_comb begin
        rx_irq = st.rx_en && |(peer_occ & ~st.rx_mask & CH_MASK);
        tx_irq = st.tx_en && |(~own_occ & ~st.tx_mask & CH_MASK);
    end

endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
    import mbox_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  flag_cmd_t [NPROC-1:0]       cmd,
    output logic [NPROC-1:0][MAX_CH-1:0] occ
);

    for (genvar p = 0; p < NPROC; p++) begin : g_own
        localparam int PEER = NPROC - 1 - p;
        always_ff @(posedge clk) begin
            if (rst) occ[p] <= '0;
            else     occ[p] <= (occ[p] & ~cmd[PEER].ack_req) | cmd[p].set_req;
        end
    end

endmodule

// File: rtl/mbox_rd_mux.sv
module mbox_rd_mux
    import mbox_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int VER_MAJOR = 2,
    parameter int VER_MINOR = 1
) (
    input  logic [ADDR_W-1:0]            addr,
    input  bank_state_t [NPROC-1:0]      st,
    input  logic [NPROC-1:0][MAX_CH-1:0] occ,
    output logic [DATA_W-1:0]            rdata
);

    dec_t        dec;
    bank_state_t sel_st;

    always_comb begin
        dec    = decode(addr);
        sel_st = st[dec.bank];
        rdata  = '0;
        if (dec.hit) begin
            case (dec.sel)
                REG_CTRL:   rdata = {15'b0, sel_st.tx_en, 15'b0, sel_st.rx_en};
                REG_MASK:   rdata = {sel_st.tx_mask, sel_st.rx_mask};
                REG_SETCLR: rdata = '0;
                REG_STAT:   rdata = {16'b0, occ[dec.bank]};
                default:    rdata = '0;
            endcase
        end else if (addr == CFG_ADDR) begin
            rdata = {24'b0, 8'(NUM_CH)};
        end else if (addr == VER_ADDR) begin
            rdata = {24'b0, 4'(VER_MAJOR), 4'(VER_MINOR)};
        end
    end

endmodule

// File: rtl/mbox_flag_ctrl.sv
module mbox_flag_ctrl
    import mbox_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int VER_MAJOR = 2,
    parameter int VER_MINOR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              p0_we,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic [DATA_W-1:0] p0_wdata,
    output logic [DATA_W-1:0] p0_rdata,
    input  logic              p1_we,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic [DATA_W-1:0] p1_wdata,
    output logic [DATA_W-1:0] p1_rdata,
    output logic [NPROC-1:0]  rx_irq,
    output logic [NPROC-1:0]  tx_irq
);

    bus_req_t    [NPROC-1:0]             req_w;
    bank_state_t [NPROC-1:0]             st_w;
    flag_cmd_t   [NPROC-1:0]             cmd_w;
    logic        [NPROC-1:0][MAX_CH-1:0] occ_w;
    logic        [NPROC-1:0][DATA_W-1:0] rdata_w;

    assign req_w[0] = {p0_we, p0_addr, p0_wdata};
    assign req_w[1] = {p1_we, p1_addr, p1_wdata};
    assign p0_rdata = rdata_w[0];
    assign p1_rdata = rdata_w[1];

    for (genvar p = 0; p < NPROC; p++) begin : g_proc
        localparam int PEER = NPROC - 1 - p;

        mbox_bank #(.NUM_CH(NUM_CH), .BANK_ID(p)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .req      (req_w[p]),
            .own_occ  (occ_w[p]),
            .peer_occ (occ_w[PEER]),
            .st       (st_w[p]),
            .cmd      (cmd_w[p]),
            .rx_irq   (rx_irq[p]),
            .tx_irq   (tx_irq[p])
        );

        mbox_rd_mux #(.NUM_CH(NUM_CH), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)) u_rd (
            .addr  (req_w[p].addr),
            .st    (st_w),
            .occ   (occ_w),
            .rdata (rdata_w[p])
        );
    end

    mbox_flags u_flags (
        .clk (clk),
        .rst (rst),
        .cmd (cmd_w),
        .occ (occ_w)
    );

endmodule

// File: rtl/mbox_flag_ctrl_chk.sv
module mbox_flag_ctrl_chk
    import mbox_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        p0_we,
    input logic [ADDR_W-1:0]           p0_addr,
    input logic [DATA_W-1:0]           p0_wdata,
    input logic [DATA_W-1:0]           p0_rdata,
    input logic                        p1_we,
    input logic [ADDR_W-1:0]           p1_addr,
    input logic [DATA_W-1:0]           p1_wdata,
    input logic [DATA_W-1:0]           p1_rdata,
    input logic [NPROC-1:0]            rx_irq,
    input logic [NPROC-1:0]            tx_irq,
    input logic [NPROC-1:0][MAX_CH-1:0] occ,
    input logic [NPROC-1:0]            rx_en
);

    localparam logic [ADDR_W-1:0] SC0 = 10'h008;
    localparam logic [ADDR_W-1:0] SC1 = 10'h018;
    localparam logic [MAX_CH-1:0] CH_MASK = ch_mask(NUM_CH);

    logic p0_set0, p0_ack0, p1_set0, p1_ack0;
    assign p0_set0 = p0_we && p0_addr == SC0 && p0_wdata[16];
    assign p0_ack0 = p0_we && p0_addr == SC0 && p0_wdata[0];
    assign p1_set0 = p1_we && p1_addr == SC1 && p1_wdata[16];
    assign p1_ack0 = p1_we && p1_addr == SC1 && p1_wdata[0];

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rx_irq == '0 && tx_irq == '0)); // R1
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        p0_set0 |=> occ[0][0]); // R2
    AST_SETCLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (p0_addr == SC0 |-> p0_rdata == '0) and (p1_addr == SC1 |-> p1_rdata == '0)); // R2
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (p0_ack0 && !p1_set0) |=> !occ[1][0]); // R3
    AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (p0_set0 && p1_ack0) |=> occ[0][0]); // R4
    AST_RX_GATED: assert property (@(posedge clk) disable iff (rst)
        (rx_irq & ~rx_en) == '0); // R5
    AST_TX_NEEDS_FREE: assert property (@(posedge clk) disable iff (rst)
        tx_irq[0] |-> ((occ[0] & CH_MASK) != CH_MASK)); // R6
    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (p0_we && p0_addr[ADDR_W-1:4] == 6'd1 && !p1_we) |=> ($stable(occ) && $stable(rx_en))); // R8

endmodule

bind mbox_flag_ctrl mbox_flag_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .p0_we    (p0_we),
    .p0_addr  (p0_addr),
    .p0_wdata (p0_wdata),
    .p0_rdata (p0_rdata),
    .p1_we    (p1_we),
    .p1_addr  (p1_addr),
    .p1_wdata (p1_wdata),
    .p1_rdata (p1_rdata),
    .rx_irq   (rx_irq),
    .tx_irq   (tx_irq),
    .occ      (occ_w),
    .rx_en    ({st_w[1].rx_en, st_w[0].rx_en})
);

// File: tb/mbox_flag_ctrl_bench.sv
`timescale 1ns/100ps
module mbox_flag_ctrl_bench;

    localparam int NCH  = 8;
    localparam int VMAJ = 2;
    localparam int VMIN = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        p0_we = 1'b0, p1_we = 1'b0;
    logic [9:0]  p0_addr = '0, p1_addr = '0;
    logic [31:0] p0_wdata = '0, p1_wdata = '0;
    logic [31:0] p0_rdata, p1_rdata;
    logic [1:0]  rx_irq, tx_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    mbox_flag_ctrl #(.NUM_CH(NCH), .VER_MAJOR(VMAJ), .VER_MINOR(VMIN)) u_mbox_flag_ctrl (
        .clk(clk), .rst(rst),
        .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
        .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
        .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    // bench model of the requirements
    logic [1:0][15:0] m_occ, m_rxm, m_txm;
    logic [1:0]       m_rxe, m_txe;
    localparam logic [15:0] IMPL = 16'((32'd1 << NCH) - 1);

    task automatic m_reset();
        m_occ = '0; m_rxe = '0; m_txe = '0;
        m_rxm = {IMPL, IMPL}; m_txm = {IMPL, IMPL};
    endtask

    function automatic logic [31:0] m_read(input logic [9:0] a);
        logic b;
        b = a[4];
        if (a[9:5] == 0 && a[1:0] == 0) begin
            case (a[3:2])
                2'd0: return {15'b0, m_txe[b], 15'b0, m_rxe[b]};
                2'd1: return {m_txm[b], m_rxm[b]};
                2'd2: return 32'h0;
                default: return {16'b0, m_occ[b]};
            endcase
        end
        if (a == 10'h3F0) return 32'(NCH);
        if (a == 10'h3F4) return 32'((VMAJ << 4) | VMIN);
        return 32'h0;
    endfunction

    task automatic m_write(input logic w0, input logic [9:0] a0, input logic [31:0] d0,
                           input logic w1, input logic [9:0] a1, input logic [31:0] d1);
        logic [1:0][15:0] set, ack;
        logic [1:0] w; logic [1:0][9:0] a; logic [1:0][31:0] d;
        set = '0; ack = '0;
        w = {w1, w0}; a = {a1, a0}; d = {d1, d0};
        for (int p = 0; p < 2; p++) begin
            if (w[p] && a[p][9:5] == 0 && a[p][1:0] == 0 && a[p][4] == p[0]) begin
                case (a[p][3:2])
                    2'd0: begin m_rxe[p] = d[p][0]; m_txe[p] = d[p][16]; end
                    2'd1: begin m_rxm[p] = d[p][15:0] & IMPL; m_txm[p] = d[p][31:16] & IMPL; end
                    2'd2: begin set[p] = d[p][31:16] & IMPL; ack[p] = d[p][15:0] & IMPL; end
                    default: ;
                endcase
            end
        end
        for (int p = 0; p < 2; p++)
            m_occ[p] = (m_occ[p] & ~ack[1-p]) | set[p];
    endtask

    function automatic logic m_rx(input int p);
        return m_rxe[p] && |(m_occ[1-p] & ~m_rxm[p]);
    endfunction

    function automatic logic m_tx(input int p);
        return m_txe[p] && |(~m_occ[p] & ~m_txm[p] & IMPL);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string reg_tag(input logic [9:0] a);
        if (a == 10'h3F0 || a == 10'h3F4 || a == 10'h100) return "R10";
        case (a[3:2])
            2'd0: return "R7";
            2'd1: return "R9";
            2'd2: return "R2";
            default: return "R3";
        endcase
    endfunction

    logic [9:0] addr_list [11] = '{10'h000, 10'h004, 10'h008, 10'h00C, 10'h010, 10'h014,
                                   10'h018, 10'h01C, 10'h3F0, 10'h3F4, 10'h100};

    // release strobes at the falling edge after a write, then check everything
    task automatic check_all(input string tag);
        @(negedge clk);
        p0_we = 1'b0; p1_we = 1'b0;
        for (int p = 0; p < 2; p++) begin
            check($sformatf("%s/R5 rx%0d", tag, p), 32'(rx_irq[p]), 32'(m_rx(p)));
            check($sformatf("%s/R6 tx%0d", tag, p), 32'(tx_irq[p]), 32'(m_tx(p)));
        end
        for (int i = 0; i < 11; i++) begin
            p0_addr = addr_list[i]; p1_addr = addr_list[i];
            #0.5;
            check($sformatf("%s/%s p0 @%h", tag, reg_tag(addr_list[i]), addr_list[i]), p0_rdata, m_read(addr_list[i]));
            check($sformatf("%s/%s p1 @%h", tag, reg_tag(addr_list[i]), addr_list[i]), p1_rdata, m_read(addr_list[i]));
        end
    endtask

    task automatic step(input logic w0, input logic [9:0] a0, input logic [31:0] d0,
                        input logic w1, input logic [9:0] a1, input logic [31:0] d1);
        @(negedge clk);
        p0_we = w0; p0_addr = a0; p0_wdata = d0;
        p1_we = w1; p1_addr = a1; p1_wdata = d1;
        m_write(w0, a0, d0, w1, a1, d1);
        @(posedge clk);
    endtask

    logic done = 1'b0;

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        check_all("R1 reset");

        // R9: upper channel bits of mask are dropped
        step(1, 10'h004, 32'hFFFF_FFFF, 0, 0, 0); check_all("R9 mask");
        // open both banks: unmask all, enable both interrupts (R7)
        step(1, 10'h004, 32'h0, 1, 10'h014, 32'h0); check_all("R11 masks");
        step(1, 10'h000, 32'hFFFF_FFFF, 1, 10'h010, 32'h0001_0001); check_all("R7 ctrl");
        // R2: p0 posts channel 3
        step(1, 10'h008, 32'h0008_0000, 0, 0, 0); check_all("R2 set");
        step(1, 10'h004, 32'hFFF7_0000, 0, 0, 0); check_all("R6 tx busy");
        // R3: p1 acknowledges channel 3
        step(0, 0, 0, 1, 10'h018, 32'h0000_0008); check_all("R3 ack");
        // R4: set and acknowledge of the same flag in one cycle
        step(1, 10'h008, 32'h0001_0000, 1, 10'h018, 32'h0000_0001); check_all("R4 collide");
        // R8: writes into the other processor's bank
        step(1, 10'h014, 32'hFFFF_FFFF, 1, 10'h008, 32'hFFFF_FFFF); check_all("R8 foreign");
        step(1, 10'h018, 32'hFFFF_FFFF, 1, 10'h000, 32'h0); check_all("R8 foreign2");
        // R11: both post in the same cycle
        step(1, 10'h008, 32'h0002_0000, 1, 10'h018, 32'h0004_0000); check_all("R11 both");
        // R9: sets above the channel count are dropped
        step(1, 10'h008, 32'hFF00_0000, 1, 10'h018, 32'hFF00_FF00); check_all("R9 high set");
        // R10: read-only words
        step(1, 10'h3F0, 32'hFFFF_FFFF, 1, 10'h3F4, 32'hFFFF_FFFF); check_all("R10 ro");
        // R5: disable p1 receive while flags pending
        step(0, 0, 0, 1, 10'h010, 32'h0001_0000); check_all("R5 gate");

        for (int it = 0; it < 1500; it++) begin
            logic [9:0] a0, a1;
            a0 = addr_list[$urandom_range(0, 9)];
            a1 = addr_list[$urandom_range(0, 9)];
            step(1'($urandom), a0, $urandom, 1'($urandom), a1, $urandom);
            check_all("RND");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule